// File: doc/BRIEF.md
# Three-Channel Down-Counting Timer

This block contains three separate 32-bit down-counters behind a small word-addressed register bus. Each channel has a reload value, a live count and a control word. The control word picks a prescaler ratio, enables the interrupt and holds a sticky underflow flag. A common start register has one run bit per channel.

A channel that is running moves its prescaler phase forward on each cycle where the peripheral clock enable is high. When the phase reaches the selected ratio, the count drops by one. A tick that finds the count at zero loads the reload value and sets the underflow flag. Each channel drives its own interrupt line.

Software starts the block by writing the reload value, the count and the control word, and then setting the run bit. When the interrupt arrives, software clears the flag.

Top module: `tmr3_top`

## Requirements
- R1: After reset every register reads 0 and all interrupt lines are low.
- R2: Bit n of the start register (address 0, bits 2:0) lets channel n run. A channel whose bit is clear keeps its count and its prescaler phase.
- R3: The control field at bits 2:0 sets the ratio. Codes 0, 1, 2, 3 and 4 give one decrement per 4, 16, 64, 256 and 1024 enabled peripheral clock cycles. The phase starts from zero.
- R4: Control codes 5, 6 and 7 never decrement the count.
- R5: Each prescaled tick lowers a nonzero count by one.
- R6: A tick that finds the count at zero loads the reload register and sets control bit 8 in that same update.
- R7: Control bit 8 stays set until a control write carries 0 in bit 8. A write with 1 in bit 8 leaves the flag as it was.
- R8: Interrupt line n is high when channel n has control bit 8 set and control bit 5 (interrupt enable) set.
- R9: A write to the count register replaces the count at the next edge and sets the channel's prescaler phase back to zero. A tick in the same cycle as the write is lost.
- R10: Cycles where the peripheral clock enable is low do not advance any prescaler.
- R11: Register map: for channel n, the reload register is at address 1+3n, the count at 2+3n and the control word at 3+3n. The control word reads back bits 2:0, 5 and 8. Other addresses read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pclk_en_i | input | 1 | Peripheral clock enable, one cycle per peripheral clock |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 3 | Per-channel underflow interrupt |

## Verification
The directed cases check the exact tick period at every ratio. A prescaler that is off by one in its compare would decrement one enabled cycle early or late. They check that a reserved code or a low clock enable freezes the count, since a design that decoded codes 5 to 7 as a ratio would keep counting. The underflow-from-zero case checks that the reload value is loaded rather than all ones left by a wrap, and that the flag rises in the same update. The flag tests show whether writing 1 wrongly clears or sets bit 8. The phase-reset test shows whether a count write leaves the old phase in place, which would make the first tick come early. Random traffic then runs writes against running channels and compares every readback and interrupt line with a cycle-level model.

// File: rtl/tmr3_pkg.sv
package tmr3_pkg;
  localparam int unsigned PRE_W        = 10;
  localparam int unsigned CODE_W       = 3;
  localparam logic [2:0]  MAX_CODE     = 3'd4;
  localparam int unsigned CTRL_IE_BIT  = 5;
  localparam int unsigned CTRL_UF_BIT  = 8;

  // all-ones mask of log2(ratio) bits: ratio = 4 << (2*code)
  function automatic logic [PRE_W-1:0] div_mask(input logic [CODE_W-1:0] code);
    logic [31:0] w;
    w = (32'd4 << {code, 1'b0}) - 32'd1;
    return w[PRE_W-1:0];
  endfunction
endpackage

// File: rtl/tmr3_prescale.sv
module tmr3_prescale
  import tmr3_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              pclk_en_i,
  input  logic              clr_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] mask;
  logic             code_ok;

  assign mask    = div_mask(code_i);
  assign code_ok = (code_i <= MAX_CODE);
  assign tick_o  = run_i & pclk_en_i & code_ok & ((phase_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 phase_q <= '0;
    else if (clr_i)              phase_q <= '0;
    else if (run_i && pclk_en_i) phase_q <= phase_q + 1'b1;
  end

  AST_PHASE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> phase_q == '0);  // R9
  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(run_i && pclk_en_i)) |=> $stable(phase_q));  // R10
endmodule

// File: rtl/tmr3_channel.sv
module tmr3_channel
  import tmr3_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          pclk_en_i,
  input  logic          rld_wr_i,
  input  logic          cnt_wr_i,
  input  logic          ctl_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rld_o,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] ctl_o,
  output logic          irq_o
);
  logic [DW-1:0]     rld_q, cnt_q;
  logic [CODE_W-1:0] code_q;
  logic              ie_q, uf_q;
  logic              tick, cnt_zero, uf_set;

  tmr3_prescale u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .pclk_en_i(pclk_en_i),
    .clr_i    (cnt_wr_i),
    .code_i   (code_q),
    .tick_o   (tick)
  );

  assign cnt_zero = (cnt_q == '0);
  assign uf_set   = tick & cnt_zero & ~cnt_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rld_q  <= '0;
      cnt_q  <= '0;
      code_q <= '0;
      ie_q   <= 1'b0;
      uf_q   <= 1'b0;
    end else begin
      if (rld_wr_i) rld_q <= wdata_i;
      if (cnt_wr_i)  cnt_q <= wdata_i;
      else if (tick) cnt_q <= cnt_zero ? rld_q : cnt_q - 1'b1;
      if (ctl_wr_i) begin
        code_q <= wdata_i[CODE_W-1:0];
        ie_q   <= wdata_i[CTRL_IE_BIT];
        uf_q   <= (uf_q & wdata_i[CTRL_UF_BIT]) | uf_set;  // write 0 clears, set wins
      end else begin
        uf_q   <= uf_q | uf_set;
      end
    end
  end

  always_comb begin
    ctl_o              = '0;
    ctl_o[CODE_W-1:0]  = code_q;
    ctl_o[CTRL_IE_BIT] = ie_q;
    ctl_o[CTRL_UF_BIT] = uf_q;
  end

  assign rld_o = rld_q;
  assign cnt_o = cnt_q;
  assign irq_o = uf_q & ie_q;

  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_wr_i) |=> $stable(cnt_q));  // R2
  AST_RSVD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q > MAX_CODE && !cnt_wr_i) |=> $stable(cnt_q));  // R4
  AST_DEC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !cnt_zero && !cnt_wr_i) |=> cnt_q == $past(cnt_q) - 1'b1);  // R5
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt_zero && !cnt_wr_i) |=> (cnt_q == $past(rld_q)) && uf_q);  // R6
  AST_UF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_q && !(ctl_wr_i && !wdata_i[CTRL_UF_BIT])) |=> uf_q);  // R7
  AST_UF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr_i && !wdata_i[CTRL_UF_BIT] && !uf_set) |=> !uf_q);  // R7
endmodule

// File: rtl/tmr3_regif.sv
module tmr3_regif #(
  parameter int unsigned N_CH   = 3,
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic [N_CH-1:0][DW-1:0]  rld_i,
  input  logic [N_CH-1:0][DW-1:0]  cnt_i,
  input  logic [N_CH-1:0][DW-1:0]  ctl_i,
  output logic [N_CH-1:0]          run_o,
  output logic [N_CH-1:0]          rld_wr_o,
  output logic [N_CH-1:0]          cnt_wr_o,
  output logic [N_CH-1:0]          ctl_wr_o,
  output logic [DW-1:0]            rdata_o
);
  localparam int unsigned REGS_PER_CH = 3;
  localparam int unsigned N_REGS      = 1 + REGS_PER_CH * N_CH;

  logic [N_CH-1:0] start_q;
  logic            start_sel;

  assign start_sel = (addr_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     start_q <= '0;
    else if (wr_en_i && start_sel)   start_q <= wdata_i[N_CH-1:0];
  end
  assign run_o = start_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_dec
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(1 + REGS_PER_CH * g);
    assign rld_wr_o[g] = wr_en_i && (addr_i == BASE);
    assign cnt_wr_o[g] = wr_en_i && (addr_i == BASE + 1'b1);
    assign ctl_wr_o[g] = wr_en_i && (addr_i == BASE + 2'd2);
  end

  always_comb begin
    rdata_o = '0;
    if (start_sel) rdata_o[N_CH-1:0] = start_q;
    for (int i = 0; i < N_CH; i++) begin
      if (addr_i == ADDR_W'(1 + REGS_PER_CH * i)) rdata_o = rld_i[i];
      if (addr_i == ADDR_W'(2 + REGS_PER_CH * i)) rdata_o = cnt_i[i];
      if (addr_i == ADDR_W'(3 + REGS_PER_CH * i)) rdata_o = ctl_i[i];
    end
  end

  initial begin
    AST_MAP_FITS: assert (N_REGS <= (1 << ADDR_W));  // R11
  end

  AST_START_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && start_sel) |=> start_q == $past(wdata_i[N_CH-1:0]));  // R2
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rld_wr_o, cnt_wr_o, ctl_wr_o}));  // R11
endmodule

// File: rtl/tmr3_top.sv
module tmr3_top #(
  parameter int unsigned N_CH   = 3,
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pclk_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [N_CH-1:0]   irq_o
);
  logic [N_CH-1:0][DW-1:0] rld, cnt, ctl;
  logic [N_CH-1:0]         run, rld_wr, cnt_wr, ctl_wr;

  tmr3_regif #(.N_CH(N_CH), .DW(DW), .ADDR_W(ADDR_W)) u_regif (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rld_i   (rld),
    .cnt_i   (cnt),
    .ctl_i   (ctl),
    .run_o   (run),
    .rld_wr_o(rld_wr),
    .cnt_wr_o(cnt_wr),
    .ctl_wr_o(ctl_wr),
    .rdata_o (rdata_o)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    tmr3_channel #(.DW(DW)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run[g]),
      .pclk_en_i(pclk_en_i),
      .rld_wr_i (rld_wr[g]),
      .cnt_wr_i (cnt_wr[g]),
      .ctl_wr_i (ctl_wr[g]),
      .wdata_i  (wdata_i),
      .rld_o    (rld[g]),
      .cnt_o    (cnt[g]),
      .ctl_o    (ctl[g]),
      .irq_o    (irq_o[g])
    );
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o[0]) |-> ctl[0][8] && ctl[0][5]);  // R8
endmodule

// File: tb/tmr3_top_tb_top.sv
`timescale 1ns/1ps
module tmr3_top_tb_top;
  logic        clk, rst_n, pen, we;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic [2:0]  irq;

  int n_chk = 0, n_bad = 0;
  logic [31:0] rd_val;

  // model state
  logic [31:0] m_rld [3];
  logic [31:0] m_cnt [3];
  logic [2:0]  m_code[3];
  logic        m_ie  [3];
  logic        m_uf  [3];
  logic [9:0]  m_ph  [3];
  logic [2:0]  m_start;

  tmr3_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pclk_en_i(pen), .wr_en_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string lbl, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", lbl, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [3:0] a);
    if (a == 0) return {29'd0, m_start};
    for (int c = 0; c < 3; c++) begin
      if (a == 4'(1 + 3*c)) return m_rld[c];
      if (a == 4'(2 + 3*c)) return m_cnt[c];
      if (a == 4'(3 + 3*c)) return {23'd0, m_uf[c], 2'b0, m_ie[c], 2'b0, m_code[c]};
    end
    return 32'd0;
  endfunction

  function automatic logic [2:0] m_irq();
    logic [2:0] r;
    for (int c = 0; c < 3; c++) r[c] = m_uf[c] & m_ie[c];
    return r;
  endfunction

  task automatic m_reset();
    for (int c = 0; c < 3; c++) begin
      m_rld[c] = 0; m_cnt[c] = 0; m_code[c] = 0; m_ie[c] = 0; m_uf[c] = 0; m_ph[c] = 0;
    end
    m_start = 0;
  endtask

  task automatic m_step(logic w, logic [3:0] a, logic [31:0] d, logic p);
    for (int c = 0; c < 3; c++) begin
      logic [9:0] msk;
      logic tk, cw, uf;
      msk = 10'(((32'd4 << (2*m_code[c])) - 1));
      tk  = m_start[c] && p && (m_code[c] <= 4) && ((m_ph[c] & msk) == msk);
      cw  = w && (a == 4'(2 + 3*c));
      uf  = tk && (m_cnt[c] == 0) && !cw;
      if (cw) begin m_cnt[c] = d; m_ph[c] = 0; end
      else begin
        if (tk) m_cnt[c] = (m_cnt[c] == 0) ? m_rld[c] : m_cnt[c] - 1;
        if (m_start[c] && p) m_ph[c] = m_ph[c] + 1;
      end
      if (w && a == 4'(3 + 3*c)) begin
        m_code[c] = d[2:0]; m_ie[c] = d[5]; m_uf[c] = m_uf[c] & d[8];
      end
      m_uf[c] = m_uf[c] | uf;
      if (w && a == 4'(1 + 3*c)) m_rld[c] = d;
    end
    if (w && a == 0) m_start = d[2:0];
  endtask

  // one bus cycle; compares readback and irq with the model every time (R11, R8)
  task automatic cyc(logic w, logic [3:0] a, logic [31:0] d, logic p);
    we = w; addr = a; wdata = d; pen = p;
    @(posedge clk);
    m_step(w, a, d, p);
    @(negedge clk);
    rd_val = rdata;
    chk($sformatf("R11 model readback addr %0d", a), rdata, m_read(a));
    chk("R8 model irq", {29'd0, irq}, {29'd0, m_irq()});
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d); cyc(1'b1, a, d, 1'b0); endtask
  task automatic rd(logic [3:0] a);                 cyc(1'b0, a, 32'd0, 1'b0); endtask
  task automatic idle(int n, logic p);
    for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, 32'd0, p);
  endtask

  logic done = 1'b0;
  initial begin
    #(8ns * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0; pen = 0; we = 0; addr = 0; wdata = 0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 12; a++) begin
      rd(4'(a));
      chk("R1 reset reg", rd_val, 32'd0);
    end
    chk("R1 reset irq", {29'd0, irq}, 32'd0);

    // R3: period of each ratio code on channel 0
    for (int k = 0; k <= 4; k++) begin
      int dv;
      dv = 4 << (2*k);
      wr(4'd0, 32'd0);
      wr(4'd3, 32'(k));
      wr(4'd2, 32'd10);
      wr(4'd0, 32'd1);
      idle(2*dv - 1, 1'b1);
      rd(4'd2); chk($sformatf("R3 code %0d one short", k), rd_val, 32'd9);
      idle(1, 1'b1);
      rd(4'd2); chk($sformatf("R3 code %0d two ticks", k), rd_val, 32'd8);
    end
    // R2: stopped channel holds
    wr(4'd0, 32'd0);
    idle(40, 1'b1);
    rd(4'd2); chk("R2 stopped holds", rd_val, 32'd8);

    // R4: reserved codes freeze
    for (int k = 5; k <= 7; k++) begin
      wr(4'd3, 32'(k));
      wr(4'd2, 32'd10);
      wr(4'd0, 32'd1);
      idle(80, 1'b1);
      rd(4'd2); chk($sformatf("R4 reserved code %0d", k), rd_val, 32'd10);
      wr(4'd0, 32'd0);
    end

    // R10: enable low, no progress
    wr(4'd3, 32'd0);
    wr(4'd2, 32'd10);
    wr(4'd0, 32'd1);
    idle(50, 1'b0);
    rd(4'd2); chk("R10 pclk_en low", rd_val, 32'd10);
    idle(4, 1'b1);
    rd(4'd2); chk("R5 single decrement", rd_val, 32'd9);
    wr(4'd0, 32'd0);

    // R6: underflow on channel 1
    wr(4'd4, 32'd5);
    wr(4'd6, 32'd0);
    wr(4'd5, 32'd0);
    wr(4'd0, 32'd2);
    idle(4, 1'b1);
    wr(4'd0, 32'd0);
    rd(4'd5); chk("R6 reload value", rd_val, 32'd5);
    rd(4'd6); chk("R6 flag set", rd_val, 32'h100);
    chk("R8 irq off while disabled", {29'd0, irq}, 32'd0);
    // R7 / R8
    wr(4'd6, 32'h120);
    chk("R8 irq on", {29'd0, irq}, 32'd2);
    rd(4'd6); chk("R7 write 1 keeps flag", rd_val, 32'h120);
    wr(4'd6, 32'h020);
    rd(4'd6); chk("R7 write 0 clears", rd_val, 32'h020);
    chk("R8 irq off after clear", {29'd0, irq}, 32'd0);
    wr(4'd6, 32'h120);
    rd(4'd6); chk("R7 write 1 does not set", rd_val, 32'h020);

    // R9: count write clears prescaler phase (channel 2)
    wr(4'd9, 32'd0);
    wr(4'd8, 32'd30);
    wr(4'd0, 32'd4);
    idle(3, 1'b1);
    wr(4'd8, 32'd20);
    idle(3, 1'b1);
    rd(4'd8); chk("R9 phase cleared", rd_val, 32'd20);
    idle(1, 1'b1);
    rd(4'd8); chk("R9 first tick", rd_val, 32'd19);

    // R11: unmapped addresses
    wr(4'd11, 32'hFFFF_FFFF);
    rd(4'd11); chk("R11 unmapped reads 0", rd_val, 32'd0);
    rd(4'd10); chk("R11 unmapped reads 0", rd_val, 32'd0);

    // random traffic against model
    for (int i = 0; i < 4000; i++) begin
      logic w;
      logic [3:0] a;
      logic [31:0] d;
      w = ($urandom_range(0, 9) < 3);
      a = 4'($urandom_range(0, 11));
      d = $urandom;
      if (a == 2 || a == 5 || a == 8 || a == 1 || a == 4 || a == 7) d = $urandom_range(0, 12);
      if (a == 3 || a == 6 || a == 9)
        d[2:0] = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'($urandom_range(0, 1));
      cyc(w, a, d, 1'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule